// File: doc/BRIEF.md
# External and Pin-Change Interrupt Front End

This block sits between a microcontroller's CPU and its pins. It watches two dedicated external interrupt inputs and sixteen general pins. Each pin passes through a synchronizer. The block then finds the trigger conditions, keeps sticky flags for them, and raises one request line per interrupt source toward the CPU. The CPU is assumed to own vector dispatch. It reports a taken vector on a per-source acknowledge line, and that acknowledge clears the matching flag.

Software reaches five byte-wide registers through a plain address/write-strobe/write-data port with combinational read data. The registers are a flag register, an enable register, a sense-control register and two pin-change mask registers. Each external input can sense a low level, any change, a falling edge or a rising edge. All enabled pin-change pins share one flag. Their enables are split unevenly over two group enables: pins 11:8 answer to group B, and pins 15:12 and 7:0 answer to group A.

Register addresses: 0 flags, 1 enables, 2 sense control, 3 mask low (pins 7:0), 4 mask high (pins 15:8). Addresses 5 to 7 read zero and ignore writes.

Top module: `irq_front`

## Requirements
- R1: After reset, the flag, enable and sense registers read 0x00, the low mask reads 0xC8 and the high mask reads 0xFF.
- R2: Both mask registers read back every bit written. The enable register keeps bits 7:4 and reads zero in bits 3:0, with bit 7 = external 1 enable, bit 6 = external 0 enable, bit 5 = group A and bit 4 = group B. The sense register keeps bits 3:0 (bits 1:0 for external 0, bits 3:2 for external 1) and reads zero above.
- R3: In the flag register, bit 7 is the external 1 flag, bit 6 the external 0 flag and bit 5 the pin-change flag. Bits 4:0 always read zero. Writing zero to a flag bit leaves that flag unchanged.
- R4: With sense code 01 (any change), 10 (falling) or 11 (rising), a matching pin transition sets the external flag. A pin level first sampled at rising edge n is seen as changed at edge n+2, and the flag reads set after that edge.
- R5: With sense code 00 (low level), the external flag is held at zero. The request then equals global enable AND source enable AND NOT the synchronized pin level, two clocks behind the pin.
- R6: A pin takes part in change detection only when its mask bit is one and its group enable is set. Pins 11:8 use group B. Pins 15:12 and 7:0 use group A.
- R7: A change in either direction on any taking-part pin sets the shared pin-change flag.
- R8: A flag is cleared by its acknowledge (ack bit 0 = external 0, bit 1 = external 1, bit 2 = pin change) or by writing one to its flag bit. A set event in the same cycle as a clear leaves the flag set.
- R9: Request bits use the acknowledge order. Each request is high only when the global enable, the source's enable and its flag are all set. For the pin-change source, the enable is group A OR group B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| ext_pin_i | input | 2 | Dedicated external interrupt pins (asynchronous) |
| pc_pin_i | input | 16 | General pins watched for changes (asynchronous) |
| ack_i | input | 3 | Vector-taken acknowledge, one per source |
| irq_o | output | 3 | Interrupt requests, one per source |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
The assertions check several rules on every cycle. The reserved flag bits always read zero. A level-sensed flag stays at zero. No request appears without the global enable. An enabled pin change always leaves the shared flag set, and an acknowledge with no competing event always clears it. Other behaviour can only be shown by the bench's scenarios, where a cycle-accurate reference model is compared against the outputs on every clock. These are the exact two-cycle latency, the uneven group split of the pin enables, the direction rules of each sense code, the priority of a set over a simultaneous clear, and the register read-back masks.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef enum logic [2:0] {
        A_FLAG  = 3'd0,
        A_ENA   = 3'd1,
        A_SENSE = 3'd2,
        A_MSKA  = 3'd3,
        A_MSKB  = 3'd4
    } reg_adr_e;

    // flag register bit positions (decoded by software)
    localparam int FLG_EXT1 = 7;
    localparam int FLG_EXT0 = 6;
    localparam int FLG_PC   = 5;

    // source indices for ack / irq vectors
    localparam int SRC_EXT0 = 0;
    localparam int SRC_EXT1 = 1;
    localparam int SRC_PC   = 2;

    localparam logic [7:0] MSKA_RST = 8'hC8;
    localparam logic [7:0] MSKB_RST = 8'hFF;

    function automatic logic edge_hit(sense_e mode, logic cur, logic old);
        unique case (mode)
            SNS_ANY:  return cur ^ old;
            SNS_FALL: return old & ~cur;
            SNS_RISE: return cur & ~old;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W       = 18,
    parameter int unsigned ARM_LEN = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    output logic [W-1:0] cur,
    output logic [W-1:0] old,
    output logic         armed
);
    logic [W-1:0]       stage1;
    logic [ARM_LEN-1:0] arm_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            cur    <= '0;
            old    <= '0;
            arm_sr <= '0;
        end else begin
            stage1 <= pin;
            cur    <= stage1;
            old    <= cur;
            arm_sr <= {arm_sr[ARM_LEN-2:0], 1'b1};
        end
    end

    // comparisons are meaningful only once 'old' holds real pin data
    assign armed = arm_sr[ARM_LEN-1];
endmodule

// File: rtl/irq_ext_trig.sv
module irq_ext_trig
    import irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_e sense,
    input  logic   cur,
    input  logic   old,
    input  logic   armed,
    input  logic   clr,
    input  logic   en,
    input  logic   gie,
    output logic   flag,
    output logic   req
);
    logic hit;
    assign hit = armed & edge_hit(sense, cur, old);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (sense == SNS_LOW)
            flag <= 1'b0;
        else
            flag <= hit | (flag & ~clr);   // set beats clear
    end

    assign req = gie & en & ((sense == SNS_LOW) ? ~cur : flag);
endmodule

// File: rtl/irq_pc_detect.sv
module irq_pc_detect #(
    parameter int unsigned N     = 16,
    parameter int unsigned GB_LO = 8,
    parameter int unsigned GB_HI = 11
) (
    input  logic [N-1:0] mask,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] old,
    input  logic         grp_a,
    input  logic         grp_b,
    input  logic         armed,
    output logic         evt
);
    logic [N-1:0] live;

    for (genvar i = 0; i < N; i++) begin : g_pin
        if (i >= GB_LO && i <= GB_HI) begin : g_grp_b
            assign live[i] = mask[i] & grp_b;
        end else begin : g_grp_a
            assign live[i] = mask[i] & grp_a;
        end
    end

    assign evt = armed & (|(live & (cur ^ old)));
endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned ARM_LEN = 3,
    parameter int unsigned GB_LO   = 8,
    parameter int unsigned GB_HI   = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gie_i,
    input  logic [1:0]      ext_pin_i,
    input  logic [2*DW-1:0] pc_pin_i,
    input  logic [2:0]      ack_i,
    output logic [2:0]      irq_o,
    input  logic [2:0]      reg_addr_i,
    input  logic            reg_wr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o
);
    localparam int unsigned NPC   = 2 * DW;
    localparam int unsigned NSYNC = NPC + 2;

    // R1 R2: configuration registers
    logic [DW-1:0] mska_q, mskb_q;
    logic [3:0]    sense_q;
    logic [1:0]    ext_en_q;
    logic          grp_a_q, grp_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mska_q   <= MSKA_RST;
            mskb_q   <= MSKB_RST;
            sense_q  <= '0;
            ext_en_q <= '0;
            grp_a_q  <= 1'b0;
            grp_b_q  <= 1'b0;
        end else if (reg_wr_i) begin
            unique case (reg_adr_e'(reg_addr_i))
                A_ENA:   {ext_en_q[1], ext_en_q[0], grp_a_q, grp_b_q} <= reg_wdata_i[7:4];
                A_SENSE: sense_q <= reg_wdata_i[3:0];
                A_MSKA:  mska_q  <= reg_wdata_i;
                A_MSKB:  mskb_q  <= reg_wdata_i;
                default: ;
            endcase
        end
    end

    // pin synchronisation, external pins on top
    logic [NSYNC-1:0] s_cur, s_old;
    logic             armed;

    irq_sync #(.W(NSYNC), .ARM_LEN(ARM_LEN)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   ({ext_pin_i, pc_pin_i}),
        .cur   (s_cur),
        .old   (s_old),
        .armed (armed)
    );

    // R8: clear sources
    logic       wr_flag;
    logic [2:0] clr;
    assign wr_flag       = reg_wr_i && (reg_adr_e'(reg_addr_i) == A_FLAG);
    assign clr[SRC_EXT0] = ack_i[SRC_EXT0] | (wr_flag & reg_wdata_i[FLG_EXT0]);
    assign clr[SRC_EXT1] = ack_i[SRC_EXT1] | (wr_flag & reg_wdata_i[FLG_EXT1]);
    assign clr[SRC_PC]   = ack_i[SRC_PC]   | (wr_flag & reg_wdata_i[FLG_PC]);

    // R4 R5: external triggers
    logic [1:0] ext_flag, ext_req;

    for (genvar g = 0; g < 2; g++) begin : g_ext
        irq_ext_trig u_trig (
            .clk   (clk),
            .rst   (rst),
            .sense (sense_e'(sense_q[2*g +: 2])),
            .cur   (s_cur[NPC+g]),
            .old   (s_old[NPC+g]),
            .armed (armed),
            .clr   (clr[g]),
            .en    (ext_en_q[g]),
            .gie   (gie_i),
            .flag  (ext_flag[g]),
            .req   (ext_req[g])
        );
    end

    // R6 R7: shared pin-change flag
    logic pc_evt, pc_flag;

    irq_pc_detect #(.N(NPC), .GB_LO(GB_LO), .GB_HI(GB_HI)) u_pcd (
        .mask  ({mskb_q, mska_q}),
        .cur   (s_cur[NPC-1:0]),
        .old   (s_old[NPC-1:0]),
        .grp_a (grp_a_q),
        .grp_b (grp_b_q),
        .armed (armed),
        .evt   (pc_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_flag <= 1'b0;
        else     pc_flag <= pc_evt | (pc_flag & ~clr[SRC_PC]);
    end

    // R9: requests
    logic [2:0] flag_vec;
    assign flag_vec = {pc_flag, ext_flag};
    assign irq_o    = {gie_i & (grp_a_q | grp_b_q) & pc_flag, ext_req};

    // R3: read mux
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_adr_e'(reg_addr_i))
            A_FLAG: begin
                reg_rdata_o[FLG_EXT1] = ext_flag[1];
                reg_rdata_o[FLG_EXT0] = ext_flag[0];
                reg_rdata_o[FLG_PC]   = pc_flag;
            end
            A_ENA:   reg_rdata_o[7:4] = {ext_en_q[1], ext_en_q[0], grp_a_q, grp_b_q};
            A_SENSE: reg_rdata_o[3:0] = sense_q;
            A_MSKA:  reg_rdata_o      = mska_q;
            A_MSKB:  reg_rdata_o      = mskb_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       gie_i,
    input logic [2:0] ack_i,
    input logic [2:0] irq_o,
    input logic [2:0] reg_addr_i,
    input logic [7:0] reg_rdata_o,
    input logic [3:0] sense_q,
    input logic [2:0] flag_vec,
    input logic       pc_evt
);
    // R3
    flag_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == 3'd0) |-> (reg_rdata_o[4:0] == 5'd0));

    // R5
    level_ext0_chk: assert property (@(posedge clk) disable iff (rst)
        (sense_q[1:0] == 2'b00) |=> !flag_vec[0]);

    // R5
    level_ext1_chk: assert property (@(posedge clk) disable iff (rst)
        (sense_q[3:2] == 2'b00) |=> !flag_vec[1]);

    // R9
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_o) |-> gie_i);

    // R7
    pc_set_chk: assert property (@(posedge clk) disable iff (rst)
        pc_evt |=> flag_vec[2]);

    // R8
    pc_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i[2] && !pc_evt) |=> !flag_vec[2]);
endmodule

bind irq_front irq_front_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .gie_i       (gie_i),
    .ack_i       (ack_i),
    .irq_o       (irq_o),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .sense_q     (sense_q),
    .flag_vec    (flag_vec),
    .pc_evt      (pc_evt)
);

// File: tb/sim_irq_front.sv
module sim_irq_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gie = 1'b0;
    logic [1:0]  ext = '0;
    logic [15:0] pc = '0;
    logic [2:0]  ack = '0;
    logic [2:0]  irq;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    irq_front u0 (
        .clk(clk), .rst(rst), .gie_i(gie), .ext_pin_i(ext), .pc_pin_i(pc),
        .ack_i(ack), .irq_o(irq), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_mska, m_mskb, m_ena;
    logic [3:0]  m_sns;
    logic [2:0]  m_flg;          // [0] ext0, [1] ext1, [2] pin change
    logic [17:0] hist[$];        // newest pin sample at index 0
    int          since_rst;

    function automatic logic ev(logic [1:0] m, logic c, logic o);
        case (m)
            2'd1:    return c != o;
            2'd2:    return o && !c;
            2'd3:    return c && !o;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [17:0] seen(int k);
        return (hist.size() > k) ? hist[k] : 18'd0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mska = 8'hC8; m_mskb = 8'hFF; m_ena = 0; m_sns = 0; m_flg = 0;
            hist.delete();
            since_rst = 0;
        end else begin
            logic [17:0] c, o;
            logic [15:0] msk;
            logic [2:0]  nf, clr;
            logic        hit, arm;
            c = seen(1); o = seen(2);
            arm = since_rst >= 3;
            msk = {m_mskb, m_mska};
            hit = 1'b0;
            for (int i = 0; i < 16; i++) begin
                logic g;
                g = (i >= 8 && i <= 11) ? m_ena[4] : m_ena[5];
                if (g && msk[i] && c[i] != o[i]) hit = 1'b1;
            end
            clr[0] = ack[0] | (wr && addr == 0 && wdata[6]);
            clr[1] = ack[1] | (wr && addr == 0 && wdata[7]);
            clr[2] = ack[2] | (wr && addr == 0 && wdata[5]);
            for (int s = 0; s < 2; s++) begin
                logic [1:0] md;
                md = m_sns[2*s +: 2];
                if (md == 0) nf[s] = 1'b0;
                else nf[s] = (arm && ev(md, c[16+s], o[16+s])) || (m_flg[s] && !clr[s]);
            end
            nf[2] = (arm && hit) || (m_flg[2] && !clr[2]);
            if (wr) begin
                case (addr)
                    3'd1: m_ena = wdata & 8'hF0;
                    3'd2: m_sns = wdata[3:0];
                    3'd3: m_mska = wdata;
                    3'd4: m_mskb = wdata;
                    default: ;
                endcase
            end
            m_flg = nf;
            hist.push_front({ext, pc});
            if (hist.size() > 4) void'(hist.pop_back());
            if (since_rst < 10) since_rst++;
        end
    end

    task automatic cmp();
        logic [2:0]  ei;
        logic [7:0]  er;
        logic [17:0] c;
        c = seen(1);
        ei[0] = gie & m_ena[6] & ((m_sns[1:0] == 0) ? ~c[16] : m_flg[0]);
        ei[1] = gie & m_ena[7] & ((m_sns[3:2] == 0) ? ~c[17] : m_flg[1]);
        ei[2] = gie & (m_ena[5] | m_ena[4]) & m_flg[2];
        case (addr)
            3'd0:    er = {m_flg[1], m_flg[0], m_flg[2], 5'd0};
            3'd1:    er = m_ena;
            3'd2:    er = {4'd0, m_sns};
            3'd3:    er = m_mska;
            3'd4:    er = m_mskb;
            default: er = 8'd0;
        endcase
        checks++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b (cycle %0d)", tag, irq, ei, cyc);
        end
        checks++;
        if (rdata !== er) begin
            fails++;
            $display("FAIL %s rdata@%0d actual=%h expected=%h (cycle %0d)", tag, addr, rdata, er, cyc);
        end
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
        cmp();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic rd(logic [2:0] a);
        addr = a;
        step();
    endtask

    task automatic wreg(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic pulse_ack(logic [2:0] a);
        ack = a;
        step();
        ack = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values of every register
        tag = "R1";
        for (int a = 0; a < 8; a++) rd(3'(a));
        idle(4);

        // R2: read-back masks of the configuration registers
        tag = "R2";
        wreg(3, 8'h5A); rd(3);
        wreg(4, 8'hA5); rd(4);
        wreg(1, 8'hFF); rd(1);
        wreg(2, 8'hFF); rd(2);
        wreg(1, 8'h00); wreg(2, 8'h00);
        wreg(3, 8'hFF); wreg(4, 8'hFF);

        // R3: reserved flag bits read zero
        tag = "R3";
        wreg(0, 8'h1F); rd(0);

        // R4: edge and change sense codes
        tag = "R4";
        gie = 1'b1;
        wreg(1, 8'hC0);
        wreg(2, 8'b0000_1001);   // ext1 falling, ext0 any change
        addr = 0;
        ext = 2'b11; idle(4);
        ext = 2'b00; idle(4);
        // R3: writing zero leaves set flags alone
        tag = "R3";
        wreg(0, 8'h00); rd(0);
        tag = "R8";
        pulse_ack(3'b001); idle(2);
        wreg(0, 8'h80); idle(2);
        tag = "R4";
        wreg(2, 8'b0000_0111);   // ext1 any change, ext0 rising
        addr = 0;
        ext = 2'b01; idle(4);
        ext = 2'b10; idle(4);
        ext = 2'b00; idle(4);
        wreg(0, 8'hC0); idle(2);

        // R5: low-level sensing
        tag = "R5";
        wreg(2, 8'h00);
        addr = 0;
        ext = 2'b11; idle(4);
        ext = 2'b01; idle(4);
        ext = 2'b10; idle(4);
        pulse_ack(3'b011);
        ext = 2'b00; idle(3);

        // R6: uneven group gating of the pin-change enables
        tag = "R6";
        wreg(1, 8'h10);          // group B only
        addr = 0;
        pc[3]  = 1'b1; idle(4);  // group A pin: no flag
        pc[13] = 1'b1; idle(4);  // group A pin: no flag
        pc[9]  = 1'b1; idle(4);  // group B pin: flag
        wreg(0, 8'h20); idle(2);
        wreg(1, 8'h20);          // group A only
        addr = 0;
        pc[9]  = 1'b0; idle(4);  // group B pin: no flag
        pc[13] = 1'b0; idle(4);  // flag
        wreg(0, 8'h20);
        addr = 0;
        pc[2] = 1'b1; idle(4);   // flag
        wreg(0, 8'h20);
        wreg(3, 8'h00); wreg(4, 8'h00); wreg(1, 8'h30);
        addr = 0;
        pc = 16'hFFFF; idle(4);  // all masked: no flag
        wreg(3, 8'hFF); wreg(4, 8'hFF);

        // R7: both directions set the shared flag
        tag = "R7";
        addr = 0;
        pc[0] = 1'b0; idle(4);
        pulse_ack(3'b100); idle(2);
        pc[0] = 1'b1; idle(4);
        pulse_ack(3'b100); idle(2);

        // R9: global enable gates every request
        tag = "R9";
        wreg(1, 8'hF0);
        wreg(2, 8'h05);
        addr = 0;
        pc[5] = 1'b0; ext = 2'b11; idle(4);
        gie = 1'b0; idle(3);
        gie = 1'b1; idle(3);
        wreg(1, 8'h00); idle(2);
        wreg(1, 8'hF0); idle(2);

        // R8: random events racing acknowledges and write-one clears
        tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(3) == 0) ext = ext ^ 2'($urandom);
            if ($urandom_range(3) == 0) pc = pc ^ (16'd1 << $urandom_range(15));
            ack = ($urandom_range(2) == 0) ? 3'($urandom) : 3'd0;
            gie = ($urandom_range(7) != 0);
            addr = ($urandom_range(1) == 0) ? 3'd0 : 3'($urandom_range(7));
            wr = ($urandom_range(3) == 0);
            wdata = 8'($urandom);
            step();
        end
        wr = 1'b0; ack = '0;
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule